// File: doc/BRIEF.md
# Lockable Binary Calendar Counter

This block keeps wall-clock time as seven binary fields: year, month, day of month, day of week, hour, minute and second. A one-second pulse from an external divider advances the calendar. The carries run from seconds through to a two-digit year offset that wraps from 99 back to 0. Month lengths come from a table, and February gains a day in every year offset that is a non-zero multiple of four. Offset 0 is kept non-leap on purpose.

Software uses a simple 32-bit register port with byte addresses on word boundaries. The port has a valid strobe, a write flag, an address and write data, and read data follows the address in the same cycle. After reset the block is locked. It refuses all register writes and does not count until a fixed series of seven key words arrives in order. Once unlocked, a stop bit lets software freeze the calendar, load a new date and time, and then let it run again.

Top module: `rtcal_top`

## Requirements
- R1: After reset: year 0, month 1, day of month 1, day of week 0, hour/minute/second 0, stop bit 1, tuning field 4, and the block locked.
- R2: Unlocking needs seven writes in this order, each of a full word: 0xC6 at 0x04, 0x9A at 0x08, 0x59 at 0x0C, 0xA3 at 0x10, 0x57 at 0x14, 0x67 at 0x18, 0xD2 at 0x1C. Any other write before the seventh restarts the series. If that write is itself the first key word, it counts as step one. Once unlocked, the block stays unlocked until reset.
- R3: While locked, writes to the control, tuning and time registers have no effect, ticks do not advance the calendar, and reads still work.
- R4: Time fields are at 0x40 + 4×i, with i = 0..6 selecting year, month, day of month, day of week, hour, minute, second. A write keeps only the field's width (7, 4, 5, 3, 5, 6, 6 bits). Reads are zero-extended and combinational from the address. Key offsets and unmapped addresses read 0.
- R5: Bit 0 at 0x20 is the stop bit. While it is 1, ticks do not change the calendar.
- R6: When unlocked and not stopped, each tick adds one second. Second 59 becomes 0 and carries to the minute, minute 59 carries to the hour, and hour 23 carries to the day.
- R7: On a day carry, the day of week goes 0..6 and wraps to 0. A day of month past the month's length becomes 1 and carries to the month. Month 12 becomes 1 and carries to the year.
- R8: A year carry from 99 gives 0.
- R9: February has 29 days when the year is a non-zero multiple of 4, and 28 days otherwise, year 0 included.
- R10: Months 4, 6, 9 and 11 have 30 days, and all other months except February have 31.
- R11: Offset 0x2C holds a 3-bit read/write tuning field in bits [2:0]. Higher written bits are dropped.
- R12: A time-field write in the same cycle as a tick takes priority: the field is loaded and the tick is dropped for the whole calendar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (8) | Byte address of the register |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for bus_addr_i |

## Verification
The hardest states to reach are the nested carries: the year wrap, and the February end in leap and non-leap offsets. Reaching them by counting would take years of ticks. The stimulus therefore unlocks the block, holds it stopped, loads a date one or two seconds before the boundary, and then releases it for a few ticks. The lock restart case needs a partial key series broken by a wrong word and then completed from the middle. The bench checks that the block is still locked afterwards by showing that a later field write has no effect.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

    localparam int YEAR_W     = 7;
    localparam int MON_W      = 4;
    localparam int DOM_W      = 5;
    localparam int DOW_W      = 3;
    localparam int HOUR_W     = 5;
    localparam int MIN_W      = 6;
    localparam int SEC_W      = 6;
    localparam int NUM_FIELDS = 7;
    localparam int KEY_STEPS  = 7;
    localparam int TUNE_W     = 3;

    localparam int YEAR_LAST = 99;
    localparam int MON_LAST  = 12;
    localparam int DOW_LAST  = 6;
    localparam int HOUR_LAST = 23;
    localparam int MIN_LAST  = 59;
    localparam int SEC_LAST  = 59;

    typedef enum logic [2:0] {
        F_YEAR = 3'd0,
        F_MON  = 3'd1,
        F_DOM  = 3'd2,
        F_DOW  = 3'd3,
        F_HOUR = 3'd4,
        F_MIN  = 3'd5,
        F_SEC  = 3'd6
    } field_e;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [DOM_W-1:0]  dom;
        logic [DOW_W-1:0]  dow;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_t;

    localparam cal_t CAL_RESET = '{
        year: '0, mon: MON_W'(1), dom: DOM_W'(1), dow: '0,
        hour: '0, min: '0, sec: '0
    };

    // Key word expected at each step of the unlock series.
    function automatic logic [7:0] key_word(int step);
        case (step)
            0:       return 8'hC6;
            1:       return 8'h9A;
            2:       return 8'h59;
            3:       return 8'hA3;
            4:       return 8'h57;
            5:       return 8'h67;
            default: return 8'hD2;
        endcase
    endfunction

    // Byte offset that carries each step of the unlock series.
    function automatic logic [7:0] key_offset(int step);
        return 8'(4 + 4 * step);
    endfunction

    function automatic logic is_leap(logic [YEAR_W-1:0] y);
        return (y != '0) && (y[1:0] == 2'b00);
    endfunction

    function automatic logic [DOM_W-1:0] month_days(logic [MON_W-1:0] m,
                                                    logic [YEAR_W-1:0] y);
        case (m)
            MON_W'(2):  return is_leap(y) ? DOM_W'(29) : DOM_W'(28);
            MON_W'(4),
            MON_W'(6),
            MON_W'(9),
            MON_W'(11): return DOM_W'(30);
            default:    return DOM_W'(31);
        endcase
    endfunction

    function automatic logic [7:0] field_value(cal_t c, field_e f);
        case (f)
            F_YEAR:  return 8'(c.year);
            F_MON:   return 8'(c.mon);
            F_DOM:   return 8'(c.dom);
            F_DOW:   return 8'(c.dow);
            F_HOUR:  return 8'(c.hour);
            F_MIN:   return 8'(c.min);
            default: return 8'(c.sec);
        endcase
    endfunction

endpackage

// File: rtl/rtcal_unlock.sv
module rtcal_unlock
    import rtcal_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              unlocked
);

    localparam int PTR_W = $clog2(KEY_STEPS + 1);
    localparam logic [PTR_W-1:0] PTR_DONE = PTR_W'(KEY_STEPS);

    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             hit_next, hit_first;

    always_comb begin
        hit_next  = (wr_addr == ADDR_W'(key_offset(int'(ptr_q)))) &&
                    (wr_data == DATA_W'(key_word(int'(ptr_q))));
        hit_first = (wr_addr == ADDR_W'(key_offset(0))) &&
                    (wr_data == DATA_W'(key_word(0)));
        ptr_d = ptr_q;
        if (wr_en && ptr_q != PTR_DONE) begin
            if (hit_next)
                ptr_d = ptr_q + PTR_W'(1);
            else if (hit_first)
                ptr_d = PTR_W'(1);
            else
                ptr_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign unlocked = (ptr_q == PTR_DONE);

    // R2
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        unlocked |=> unlocked);

    // R2
    key_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ptr_q));

endmodule

// File: rtl/rtcal_calendar.sv
module rtcal_calendar
    import rtcal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  logic       wr_en,
    input  field_e     wr_sel,
    input  logic [7:0] wr_val,
    output cal_t       cal
);

    cal_t cal_q, cal_d, adv;
    logic sec_wrap, min_wrap, hour_wrap, dom_wrap, mon_wrap, dow_wrap, year_wrap;
    logic min_roll, hour_roll, day_roll, mon_roll, year_roll;
    logic [DOM_W-1:0] last_dom;

    always_comb begin
        last_dom  = month_days(cal_q.mon, cal_q.year);
        sec_wrap  = cal_q.sec  >= SEC_W'(SEC_LAST);
        min_wrap  = cal_q.min  >= MIN_W'(MIN_LAST);
        hour_wrap = cal_q.hour >= HOUR_W'(HOUR_LAST);
        dow_wrap  = cal_q.dow  >= DOW_W'(DOW_LAST);
        dom_wrap  = cal_q.dom  >= last_dom;
        mon_wrap  = cal_q.mon  >= MON_W'(MON_LAST);
        year_wrap = cal_q.year >= YEAR_W'(YEAR_LAST);

        min_roll  = sec_wrap;
        hour_roll = min_roll  && min_wrap;
        day_roll  = hour_roll && hour_wrap;
        mon_roll  = day_roll  && dom_wrap;
        year_roll = mon_roll  && mon_wrap;

        adv = cal_q;
        adv.sec = sec_wrap ? '0 : cal_q.sec + 1'b1;
        if (min_roll)  adv.min  = min_wrap  ? '0 : cal_q.min + 1'b1;
        if (hour_roll) adv.hour = hour_wrap ? '0 : cal_q.hour + 1'b1;
        if (day_roll) begin
            adv.dow = dow_wrap ? '0 : cal_q.dow + 1'b1;
            adv.dom = dom_wrap ? DOM_W'(1) : cal_q.dom + 1'b1;
        end
        if (mon_roll)  adv.mon  = mon_wrap  ? MON_W'(1) : cal_q.mon + 1'b1;
        if (year_roll) adv.year = year_wrap ? '0 : cal_q.year + 1'b1;
    end

    always_comb begin
        cal_d = cal_q;
        if (wr_en) begin
            case (wr_sel)
                F_YEAR:  cal_d.year = wr_val[YEAR_W-1:0];
                F_MON:   cal_d.mon  = wr_val[MON_W-1:0];
                F_DOM:   cal_d.dom  = wr_val[DOM_W-1:0];
                F_DOW:   cal_d.dow  = wr_val[DOW_W-1:0];
                F_HOUR:  cal_d.hour = wr_val[HOUR_W-1:0];
                F_MIN:   cal_d.min  = wr_val[MIN_W-1:0];
                default: cal_d.sec  = wr_val[SEC_W-1:0];
            endcase
        end else if (step) begin
            cal_d = adv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cal_q <= CAL_RESET;
        else     cal_q <= cal_d;
    end

    assign cal = cal_q;

    // R6
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && cal_q.sec < SEC_W'(SEC_LAST)) |=>
        (cal_q.sec == $past(cal_q.sec) + 1'b1));

    // R7
    dow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && day_roll && cal_q.dow == DOW_W'(DOW_LAST)) |=>
        (cal_q.dow == '0));

    // R8
    year_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en && year_roll && cal_q.year == YEAR_W'(YEAR_LAST)) |=>
        (cal_q.year == '0));

    // R12
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel != F_SEC) |=> $stable(cal_q.sec));

endmodule

// File: rtl/rtcal_top.sv
module rtcal_top
    import rtcal_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int TUNE_INIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o
);

    localparam logic [ADDR_W-1:0] CTL_ADDR  = ADDR_W'(8'h20);
    localparam logic [ADDR_W-1:0] TUNE_ADDR = ADDR_W'(8'h2C);
    localparam logic [ADDR_W-1:0] FLD_BASE  = ADDR_W'(8'h40);
    localparam logic [ADDR_W-1:0] FLD_END   = FLD_BASE + ADDR_W'(4 * NUM_FIELDS);

    logic              wr, unlocked, fld_hit, fld_wr, step;
    logic              stop_q;
    logic [TUNE_W-1:0] tune_q;
    logic [ADDR_W-1:0] fld_off;
    field_e            fld_sel;
    cal_t              cal;
    logic [DATA_W-9:0] wdata_unused;

    assign wdata_unused = bus_wdata_i[DATA_W-1:8];

    assign wr      = bus_valid_i && bus_write_i;
    assign fld_off = bus_addr_i - FLD_BASE;
    assign fld_sel = field_e'(fld_off[4:2]);
    assign fld_hit = (bus_addr_i[1:0] == 2'b00) &&
                     (bus_addr_i >= FLD_BASE) && (bus_addr_i < FLD_END);
    assign fld_wr  = wr && unlocked && fld_hit;
    assign step    = tick_i && unlocked && !stop_q && !fld_wr;

    rtcal_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr),
        .wr_addr  (bus_addr_i),
        .wr_data  (bus_wdata_i),
        .unlocked (unlocked)
    );

    rtcal_calendar u_cal (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .wr_en  (fld_wr),
        .wr_sel (fld_sel),
        .wr_val (bus_wdata_i[7:0]),
        .cal    (cal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b1;
            tune_q <= TUNE_W'(TUNE_INIT);
        end else if (wr && unlocked) begin
            if (bus_addr_i == CTL_ADDR)  stop_q <= bus_wdata_i[0];
            if (bus_addr_i == TUNE_ADDR) tune_q <= bus_wdata_i[TUNE_W-1:0];
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (fld_hit)
            bus_rdata_o = DATA_W'(field_value(cal, fld_sel));
        else if (bus_addr_i == CTL_ADDR)
            bus_rdata_o = DATA_W'(stop_q);
        else if (bus_addr_i == TUNE_ADDR)
            bus_rdata_o = DATA_W'(tune_q);
    end

    // R3
    locked_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> ($stable(cal) && $stable(stop_q) && $stable(tune_q)));

    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !fld_wr) |=> $stable(cal));

endmodule

// File: tb/rtcal_top_tb.sv
`timescale 1ns/1ps
module rtcal_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic        v, w;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] rd;

    always #5 clk = ~clk;

    rtcal_top u_dut (
        .clk(clk), .rst(rst), .tick_i(tick),
        .bus_valid_i(v), .bus_write_i(w), .bus_addr_i(addr),
        .bus_wdata_i(wd), .bus_rdata_o(rd)
    );

    int n_cmp = 0;
    int n_bad = 0;
    // model: 0 year,1 month,2 dom,3 dow,4 hour,5 minute,6 second
    int m_f[7];
    int m_lock, m_stop, m_tune;
    int keys[7]  = '{32'hC6, 32'h9A, 32'h59, 32'hA3, 32'h57, 32'h67, 32'hD2};
    int fmask[7] = '{127, 15, 31, 7, 31, 63, 63};

    function automatic int mdays(int m, int y);
        if (m == 2) return (y != 0 && y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic int exp_rd(int a);
        if (a >= 'h40 && a < 'h5C && a % 4 == 0) return m_f[(a - 'h40) / 4];
        if (a == 'h20) return m_stop;
        if (a == 'h2C) return m_tune;
        return 0;
    endfunction

    task automatic advance();
        m_f[6]++;
        if (m_f[6] > 59) begin
            m_f[6] = 0; m_f[5]++;
            if (m_f[5] > 59) begin
                m_f[5] = 0; m_f[4]++;
                if (m_f[4] > 23) begin
                    m_f[4] = 0;
                    m_f[3] = (m_f[3] + 1) % 7;
                    m_f[2]++;
                    if (m_f[2] > mdays(m_f[1], m_f[0])) begin
                        m_f[2] = 1; m_f[1]++;
                        if (m_f[1] > 12) begin
                            m_f[1] = 1;
                            m_f[0] = (m_f[0] == 99) ? 0 : m_f[0] + 1;
                        end
                    end
                end
            end
        end
    endtask

    task automatic cyc(bit vv, bit ww, int a, int d, bit t, string tag);
        bit unl, fw, run;
        @(negedge clk);
        v = vv; w = ww; addr = a[7:0]; wd = d; tick = t;
        #1;
        n_cmp++;
        if (rd !== exp_rd(a)) begin
            n_bad++;
            $display("FAIL %s: addr 0x%02h actual 0x%08h expected 0x%08h",
                     tag, a, rd, exp_rd(a));
        end
        unl = (m_lock == 7);
        fw  = 0;
        if (vv && ww && unl && a >= 'h40 && a < 'h5C && a % 4 == 0) fw = 1;
        run = t && unl && (m_stop == 0) && !fw;
        if (vv && ww) begin
            if (!unl) begin
                if (a == 4 + 4 * m_lock && d == keys[m_lock]) m_lock++;
                else if (a == 4 && d == keys[0]) m_lock = 1;
                else m_lock = 0;
            end else begin
                if (a == 'h20) m_stop = d & 1;
                if (a == 'h2C) m_tune = d & 7;
                if (fw) m_f[(a - 'h40) / 4] = d & fmask[(a - 'h40) / 4];
            end
        end
        if (run) advance();
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < 7; i++) cyc(1, 0, 'h40 + 4 * i, 0, 0, tag);
        cyc(1, 0, 'h20, 0, 0, tag);
        cyc(1, 0, 'h2C, 0, 0, tag);
    endtask

    task automatic set_time(int y, int mo, int dd, int dw, int h, int mi, int s);
        int vals[7];
        vals = '{y, mo, dd, dw, h, mi, s};
        for (int i = 0; i < 7; i++) cyc(1, 1, 'h40 + 4 * i, vals[i], 0, "R4");
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 'h58, 0, 1, tag);
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1; v = 0; w = 0; addr = 0; wd = 0; tick = 0;
        m_f = '{0, 1, 1, 0, 0, 0, 0};
        m_lock = 0; m_stop = 1; m_tune = 4;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset values
        sweep("R1");

        // R3 writes and ticks while locked
        cyc(1, 1, 'h58, 30, 0, "R3");
        cyc(1, 1, 'h20, 0, 0, "R3");
        cyc(1, 1, 'h2C, 1, 0, "R3");
        ticks(3, "R3");
        sweep("R3");

        // R2 broken series, then finishing from the middle stays locked
        for (int i = 0; i < 3; i++) cyc(1, 1, 4 + 4 * i, keys[i], 0, "R2");
        cyc(1, 1, 'h10, 0, 0, "R2");
        for (int i = 3; i < 7; i++) cyc(1, 1, 4 + 4 * i, keys[i], 0, "R2");
        cyc(1, 1, 'h58, 17, 0, "R2");
        sweep("R2");
        // R2 upper bits must match too; a repeated first key restarts at step one
        cyc(1, 1, 4, 'h1C6, 0, "R2");
        cyc(1, 1, 4, keys[0], 0, "R2");
        cyc(1, 1, 4, keys[0], 0, "R2");
        for (int i = 1; i < 7; i++) cyc(1, 1, 4 + 4 * i, keys[i], 0, "R2");

        // R5 still stopped after unlock
        ticks(3, "R5");
        set_time(24, 6, 15, 2, 10, 20, 30);
        sweep("R4");
        cyc(1, 1, 'h44, 'hFF, 0, "R4");
        cyc(1, 0, 'h30, 0, 0, "R4");
        cyc(1, 0, 'h08, 0, 0, "R4");
        cyc(1, 1, 'h44, 6, 0, "R4");

        // R6 running
        cyc(1, 1, 'h20, 0, 0, "R6");
        ticks(5, "R6");
        set_time(24, 6, 15, 2, 10, 58, 58);
        ticks(3, "R6");
        sweep("R6");

        // R5 stop again
        cyc(1, 1, 'h20, 1, 0, "R5");
        ticks(4, "R5");
        sweep("R5");
        cyc(1, 1, 'h20, 0, 0, "R5");

        // R7 R8 end of year 99
        set_time(99, 12, 31, 6, 23, 59, 58);
        ticks(2, "R8");
        sweep("R7");

        // R9 February
        set_time(0, 2, 28, 3, 23, 59, 59);
        ticks(1, "R9");
        sweep("R9");
        set_time(4, 2, 28, 3, 23, 59, 59);
        ticks(1, "R9");
        sweep("R9");
        set_time(4, 2, 29, 4, 23, 59, 59);
        ticks(1, "R9");
        sweep("R9");
        set_time(7, 2, 28, 1, 23, 59, 59);
        ticks(1, "R9");
        sweep("R9");

        // R10 month lengths
        set_time(10, 4, 30, 0, 23, 59, 59);
        ticks(1, "R10");
        sweep("R10");
        set_time(10, 1, 30, 0, 23, 59, 59);
        ticks(1, "R10");
        sweep("R10");
        set_time(10, 11, 30, 5, 23, 59, 59);
        ticks(1, "R10");
        sweep("R10");

        // R11 tuning field
        cyc(1, 1, 'h2C, 'hFF, 0, "R11");
        cyc(1, 0, 'h2C, 0, 0, "R11");
        cyc(1, 1, 'h2C, 0, 0, "R11");
        cyc(1, 0, 'h2C, 0, 0, "R11");

        // R12 field write beats a simultaneous tick
        set_time(20, 3, 3, 3, 3, 3, 3);
        cyc(1, 1, 'h58, 10, 1, "R12");
        cyc(1, 1, 'h50, 5, 1, "R12");
        sweep("R12");
        ticks(2, "R12");
        sweep("R12");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule